// File: doc/BRIEF.md
# Deferred Load Return Buffer

This block sits between the vector memory return path and the vector register file of one compute unit. When a vector load comes back from memory, its full row of lanes is not written into the destination register straight away. It is parked in a small buffer shared by all wavefronts. The row moves to its register only when the wavefront that issued the load executes a wait instruction and that wait's threshold is met. A destination register therefore needs to be live only from the wait onwards, not from the moment the load was issued.

Each wavefront has an outstanding-load count. The count rises when the load is issued and falls when the data reaches the buffer, not when the data reaches the register file. A wait compares this count with its threshold. Once the wait is satisfied, the wavefront stays stalled while its parked rows drain into the register file, one row per cycle. A round-robin choice among the wavefronts decides which row goes in each cycle. Issue is refused whenever an extra load could leave a returning row with no buffer slot to land in. This keeps every wait reachable.

Returns for a given wavefront arrive in the order that wavefront issued its loads. The return port names the wavefront. The destination register is remembered from the issue.

Top module: `deferred_load_buffer`

## Requirements
- R1: After reset no wavefront is stalled, no register-file write is presented, and both the issue port and the return port are ready.
- R2: A wavefront whose outstanding count is 15 (the ceiling of its 4-bit counter) has further issues refused with `iss_ready` low, even when buffer space remains.
- R3: A returned row is never written to the register file before its wavefront has a satisfied wait. Writes appear only for a wavefront whose `stall` bit is high.
- R4: A wait with threshold T keeps the wavefront stalled and writes nothing while its outstanding count exceeds T. The release begins in the cycle after the count becomes less than or equal to T.
- R5: Released rows are written in the wavefront's issue order. Each write carries the destination register given at issue and the 64 lanes × 32 bits returned for that load.
- R6: After a wait is satisfied, `stall` stays high until every row released by that wait has been written. For k released rows with the count already within the threshold, `stall` is high for exactly k+2 cycles, counted from the cycle after the wait is presented.
- R7: When several wavefronts have released rows pending, grants rotate round-robin with one row per cycle. Two wavefronts draining together alternate write by write.
- R8: An issue is refused when the sum of all outstanding loads and all occupied buffer entries equals the number of entries (16).
- R9: `ret_ready` is low exactly when every buffer entry holds a parked row.
- R10: The outstanding count falls when a row enters the buffer. A wait can therefore be satisfied, and release exactly the rows already parked, before any of them has been written.
- R11: Rows that return after a wait was satisfied stay parked. The next satisfied wait releases them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Vector load issue request |
| iss_wf | input | 2 | Issuing wavefront |
| iss_reg | input | 8 | Destination vector register |
| iss_ready | output | 1 | Issue accepted this cycle when high |
| ret_valid | input | 1 | Returned row present |
| ret_wf | input | 2 | Wavefront the row belongs to |
| ret_data | input | 2048 | 64 lanes of 32-bit data |
| ret_ready | output | 1 | A free buffer entry exists |
| wait_valid | input | 1 | Wait instruction presented |
| wait_wf | input | 2 | Waiting wavefront |
| wait_thr | input | 4 | Outstanding-count threshold |
| stall | output | 4 | Per-wavefront stall |
| rf_we | output | 1 | Register-file row write |
| rf_wf | output | 2 | Wavefront of the written row |
| rf_reg | output | 8 | Destination register of the written row |
| rf_data | output | 2048 | Row data |

## Verification
The hardest case to reach from the ports is two wavefronts whose waits are satisfied one cycle apart, so that both have released rows competing for the single write port. The stimulus issues four loads from each of two wavefronts and returns all but the last row of each. It then blocks both wavefronts on a zero-threshold wait, and finally returns the two missing rows on consecutive cycles. That yields a fixed, computable interleaving. A second hard case is a buffer that is completely full while no wait is pending. It is reached by reserving every entry across all four wavefronts before any data returns. Sweeps over the load count (0 to 15) and over the wait threshold give the arithmetic stall lengths and write counts.

// File: rtl/deferred_load_buffer.sv
module deferred_load_buffer #(
  parameter int NUM_WF  = 4,
  parameter int WF_W    = (NUM_WF > 1) ? $clog2(NUM_WF) : 1,
  parameter int ENTRIES = 16,
  parameter int LANES   = 64,
  parameter int DW      = 32,
  parameter int REG_W   = 8,
  parameter int CNT_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iss_valid,
  input  logic [WF_W-1:0]        iss_wf,
  input  logic [REG_W-1:0]       iss_reg,
  output logic                   iss_ready,
  input  logic                   ret_valid,
  input  logic [WF_W-1:0]        ret_wf,
  input  logic [LANES*DW-1:0]    ret_data,
  output logic                   ret_ready,
  input  logic                   wait_valid,
  input  logic [WF_W-1:0]        wait_wf,
  input  logic [CNT_W-1:0]       wait_thr,
  output logic [NUM_WF-1:0]      stall,
  output logic                   rf_we,
  output logic [WF_W-1:0]        rf_wf,
  output logic [REG_W-1:0]       rf_reg,
  output logic [LANES*DW-1:0]    rf_data
);

  localparam int ROW_W   = LANES * DW;
  localparam int SEQ_W   = CNT_W + 1;
  localparam int QD      = 1 << CNT_W;
  localparam int ENT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int RES_W   = $clog2(ENTRIES + NUM_WF * QD) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {WS_IDLE, WS_WAIT, WS_DRAIN} wstate_t;

  logic [SEQ_W-1:0] iss_seq [NUM_WF];
  logic [SEQ_W-1:0] ret_seq [NUM_WF];
  logic [SEQ_W-1:0] rd_seq  [NUM_WF];
  logic [CNT_W-1:0] thr_q   [NUM_WF];
  wstate_t          ws      [NUM_WF];
  logic [REG_W-1:0] tagq    [NUM_WF][QD];

  logic [ENTRIES-1:0] e_vld, e_rel;
  logic [WF_W-1:0]    e_wf   [ENTRIES];
  logic [REG_W-1:0]   e_reg  [ENTRIES];
  logic [SEQ_W-1:0]   e_seq  [ENTRIES];
  logic [ROW_W-1:0]   e_data [ENTRIES];

  logic [CNT_W-1:0]  cnt      [NUM_WF];
  logic [NUM_WF-1:0] met, any_rel, head_hit;
  logic [ENT_W-1:0]  head_idx [NUM_WF];
  logic [RES_W-1:0]  res_total;
  logic [ENT_W-1:0]  free_idx, gnt_ent;
  logic              has_free, gnt_vld;
  logic [WF_W-1:0]   gnt_wf, rr;
  logic              iss_ok, ret_ok;

  always_comb begin
    res_total = '0;
    for (int w = 0; w < NUM_WF; w++) begin
      cnt[w]    = CNT_W'(iss_seq[w] - ret_seq[w]);
      met[w]    = (ws[w] == WS_WAIT) && (cnt[w] <= thr_q[w]);
      res_total = res_total + RES_W'(cnt[w]);
    end
    for (int e = 0; e < ENTRIES; e++)
      res_total = res_total + RES_W'(e_vld[e]);
  end

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (!e_vld[e]) begin
        has_free = 1'b1;
        free_idx = ENT_W'(e);
      end
  end

  always_comb begin
    any_rel  = '0;
    head_hit = '0;
    for (int w = 0; w < NUM_WF; w++) head_idx[w] = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (e_vld[e] && e_rel[e]) begin
        any_rel[e_wf[e]] = 1'b1;
        if (e_seq[e] == rd_seq[e_wf[e]]) begin
          head_hit[e_wf[e]] = 1'b1;
          head_idx[e_wf[e]] = ENT_W'(e);
        end
      end
  end

  always_comb begin
    gnt_vld = 1'b0;
    gnt_wf  = '0;
    for (int i = 1; i <= NUM_WF; i++) begin
      int c;
      c = (int'(rr) + i) % NUM_WF;
      if (!gnt_vld && head_hit[c]) begin
        gnt_vld = 1'b1;
        gnt_wf  = WF_W'(c);
      end
    end
    gnt_ent = head_idx[gnt_wf];
  end

  assign iss_ready = (cnt[iss_wf] != CNT_MAX) && (res_total < RES_W'(ENTRIES));
  assign ret_ready = has_free;
  assign iss_ok    = iss_valid && iss_ready;
  assign ret_ok    = ret_valid && has_free && (cnt[ret_wf] != '0);

  assign rf_we   = gnt_vld;
  assign rf_wf   = gnt_wf;
  assign rf_reg  = e_reg[gnt_ent];
  assign rf_data = e_data[gnt_ent];

  for (genvar w = 0; w < NUM_WF; w++) begin : g_stall
    assign stall[w] = (ws[w] != WS_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WF; w++) begin
        iss_seq[w] <= '0;
        ret_seq[w] <= '0;
        rd_seq[w]  <= '0;
        thr_q[w]   <= '0;
        ws[w]      <= WS_IDLE;
      end
      for (int e = 0; e < ENTRIES; e++) begin
        e_wf[e]  <= '0;
        e_reg[e] <= '0;
        e_seq[e] <= '0;
      end
      e_vld <= '0;
      e_rel <= '0;
      rr    <= WF_W'(NUM_WF - 1);
    end else begin
      if (iss_ok) iss_seq[iss_wf] <= iss_seq[iss_wf] + 1'b1;

      if (ret_ok) begin
        ret_seq[ret_wf]  <= ret_seq[ret_wf] + 1'b1;
        e_vld[free_idx]  <= 1'b1;
        e_rel[free_idx]  <= 1'b0;
        e_wf[free_idx]   <= ret_wf;
        e_seq[free_idx]  <= ret_seq[ret_wf];
        e_reg[free_idx]  <= tagq[ret_wf][ret_seq[ret_wf][CNT_W-1:0]];
      end

      for (int e = 0; e < ENTRIES; e++)
        if (e_vld[e] && met[e_wf[e]]) e_rel[e] <= 1'b1;

      if (gnt_vld) begin
        e_vld[gnt_ent]  <= 1'b0;
        e_rel[gnt_ent]  <= 1'b0;
        rd_seq[gnt_wf]  <= rd_seq[gnt_wf] + 1'b1;
        rr              <= gnt_wf;
      end

      for (int w = 0; w < NUM_WF; w++)
        case (ws[w])
          WS_IDLE:
            if (wait_valid && wait_wf == WF_W'(w)) begin
              ws[w]    <= WS_WAIT;
              thr_q[w] <= wait_thr;
            end
          WS_WAIT:  if (met[w])      ws[w] <= WS_DRAIN;
          WS_DRAIN: if (!any_rel[w]) ws[w] <= WS_IDLE;
          default:                   ws[w] <= WS_IDLE;
        endcase
    end
  end

  always_ff @(posedge clk) begin
    if (iss_ok) tagq[iss_wf][iss_seq[iss_wf][CNT_W-1:0]] <= iss_reg;
    if (ret_ok) e_data[free_idx] <= ret_data;
  end

endmodule

module deferred_load_buffer_chk #(
  parameter int NUM_WF = 4,
  parameter int WF_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wait_valid,
  input logic [WF_W-1:0]   wait_wf,
  input logic [NUM_WF-1:0] stall,
  input logic              rf_we,
  input logic [WF_W-1:0]   rf_wf,
  input logic              iss_ready,
  input logic              ret_ready
);

  AST_WRITE_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> stall[rf_wf]); // R3

  AST_FULL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) !ret_ready |-> !iss_ready); // R8

  for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
    AST_STALL_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall[w]) |-> $past(wait_valid && wait_wf == WF_W'(w))); // R4

    AST_MIN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall[w]) |=> stall[w]); // R6

    AST_DRAIN_BEFORE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall[w]) |-> $past(!(rf_we && rf_wf == WF_W'(w)))); // R6
  end

endmodule

bind deferred_load_buffer deferred_load_buffer_chk #(.NUM_WF(NUM_WF), .WF_W(WF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_valid(wait_valid), .wait_wf(wait_wf),
  .stall(stall), .rf_we(rf_we), .rf_wf(rf_wf),
  .iss_ready(iss_ready), .ret_ready(ret_ready)
);

// File: tb/deferred_load_buffer_tb_top.sv
`timescale 1ns/100ps
module deferred_load_buffer_tb_top;

  localparam int ROW_W = 64 * 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             iss_valid = 1'b0;
  logic [1:0]       iss_wf = '0;
  logic [7:0]       iss_reg = '0;
  logic             iss_ready;
  logic             ret_valid = 1'b0;
  logic [1:0]       ret_wf = '0;
  logic [ROW_W-1:0] ret_data = '0;
  logic             ret_ready;
  logic             wait_valid = 1'b0;
  logic [1:0]       wait_wf = '0;
  logic [3:0]       wait_thr = '0;
  logic [3:0]       stall;
  logic             rf_we;
  logic [1:0]       rf_wf;
  logic [7:0]       rf_reg;
  logic [ROW_W-1:0] rf_data;

  deferred_load_buffer dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_wf(iss_wf), .iss_reg(iss_reg), .iss_ready(iss_ready),
    .ret_valid(ret_valid), .ret_wf(ret_wf), .ret_data(ret_data), .ret_ready(ret_ready),
    .wait_valid(wait_valid), .wait_wf(wait_wf), .wait_thr(wait_thr),
    .stall(stall), .rf_we(rf_we), .rf_wf(rf_wf), .rf_reg(rf_reg), .rf_data(rf_data)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0;
  int exp_reg [4][64];
  int exp_n [4], ret_ptr [4], chk_ptr [4];
  int wr_wf [256], wr_reg [256];
  int wr_n = 0, data_bad = 0;

  function automatic logic [ROW_W-1:0] pat(int w, int r);
    logic [ROW_W-1:0] p;
    for (int l = 0; l < 64; l++) p[l*32 +: 32] = {8'(w), 8'(r), 16'(l * 3 + 1)};
    return p;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n && rf_we && wr_n < 256) begin
    wr_wf[wr_n]  = int'(rf_wf);
    wr_reg[wr_n] = int'(rf_reg);
    if (rf_data !== pat(int'(rf_wf), int'(rf_reg))) data_bad++;
    wr_n++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic clear();
    for (int w = 0; w < 4; w++) begin exp_n[w] = 0; ret_ptr[w] = 0; chk_ptr[w] = 0; end
    wr_n = 0;
    data_bad = 0;
  endtask

  task automatic do_issue(int w, int r, output bit ok);
    iss_valid = 1'b1; iss_wf = 2'(w); iss_reg = 8'(r);
    #1 ok = iss_ready;
    @(negedge clk);
    iss_valid = 1'b0;
    if (ok) begin exp_reg[w][exp_n[w]] = r; exp_n[w]++; end
  endtask

  task automatic do_ret(int w);
    ret_valid = 1'b1; ret_wf = 2'(w);
    ret_data = pat(w, exp_reg[w][ret_ptr[w]]);
    ret_ptr[w]++;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic do_wait(int w, int t);
    wait_valid = 1'b1; wait_wf = 2'(w); wait_thr = 4'(t);
    @(negedge clk);
    wait_valid = 1'b0;
  endtask

  task automatic stall_len(int w, output int n);
    n = 0;
    while (stall[w] && n < 200) begin n++; @(negedge clk); end
  endtask

  task automatic verify_writes(string req, int total);
    chk(wr_n == total, req, wr_n, total);
    for (int i = 0; i < wr_n && i < total; i++) begin
      int w;
      w = wr_wf[i];
      chk(wr_reg[i] == exp_reg[w][chk_ptr[w]], req, wr_reg[i], exp_reg[w][chk_ptr[w]]);
      chk_ptr[w]++;
    end
    chk(data_bad == 0, req, data_bad, 0);
  endtask

  initial begin
    bit ok;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(stall == 4'b0, "R1 stall", int'(stall), 0);
    chk(rf_we == 1'b0, "R1 rf_we", int'(rf_we), 0);
    chk(iss_ready == 1'b1, "R1 iss_ready", int'(iss_ready), 1);
    chk(ret_ready == 1'b1, "R1 ret_ready", int'(ret_ready), 1);

    // R5 R6 R3: sweep load count with all data back before the wait
    for (int k = 0; k < 16; k++) begin
      int w;
      w = k % 4;
      clear();
      for (int j = 0; j < k; j++) begin
        do_issue(w, (k * 13 + j * 7) % 256, ok);
        chk(ok, "R5 issue accept", int'(ok), 1);
      end
      for (int j = 0; j < k; j++) do_ret(w);
      @(negedge clk);
      chk(wr_n == 0, "R3 no write before wait", wr_n, 0);
      do_wait(w, 0);
      stall_len(w, n);
      chk(n == k + 2, "R6 stall length", n, k + 2);
      verify_writes("R5 order/data", k);
    end

    // R2 counter ceiling
    clear();
    for (int j = 0; j < 15; j++) begin
      do_issue(1, 100 + j, ok);
      chk(ok, "R2 accept below ceiling", int'(ok), 1);
    end
    do_issue(1, 200, ok);
    chk(!ok, "R2 refuse at 15", int'(ok), 0);
    for (int j = 0; j < 15; j++) do_ret(1);
    do_wait(1, 0);
    stall_len(1, n);
    chk(n == 17, "R2 drain length", n, 17);
    verify_writes("R2 writes", 15);

    // R4 R10 R11 threshold sweep
    for (int t = 0; t < 5; t++) begin
      clear();
      for (int j = 0; j < 5; j++) do_issue(2, 40 + t * 8 + j, ok);
      do_wait(2, t);
      for (int i = 0; i < 5 - t; i++) begin
        chk(wr_n == 0 && stall[2], "R4 held above threshold", wr_n, 0);
        do_ret(2);
      end
      stall_len(2, n);
      chk(wr_n == 5 - t, "R10 released parked rows", wr_n, 5 - t);
      for (int i = 0; i < t; i++) begin
        do_ret(2);
        repeat (2) @(negedge clk);
        chk(wr_n == 5 - t, "R11 late rows parked", wr_n, 5 - t);
      end
      do_wait(2, 0);
      stall_len(2, n);
      verify_writes("R11 second release", 5);
    end

    // R7 round robin between two draining wavefronts
    clear();
    for (int j = 0; j < 4; j++) do_issue(0, 10 + j, ok);
    for (int j = 0; j < 4; j++) do_issue(1, 20 + j, ok);
    for (int j = 0; j < 3; j++) do_ret(0);
    for (int j = 0; j < 3; j++) do_ret(1);
    do_wait(0, 0);
    do_wait(1, 0);
    chk(wr_n == 0, "R4 both blocked", wr_n, 0);
    do_ret(0);
    do_ret(1);
    n = 0;
    while ((stall[0] || stall[1]) && n < 200) begin n++; @(negedge clk); end
    verify_writes("R7 writes", 8);
    chk(wr_wf[0] == 0, "R7 first grant", wr_wf[0], 0);
    for (int i = 1; i < 8; i++)
      chk(wr_wf[i] != wr_wf[i-1], "R7 alternation", wr_wf[i], 1 - wr_wf[i-1]);

    // R8 R9 reservation and full buffer
    clear();
    for (int w = 0; w < 4; w++)
      for (int j = 0; j < 4; j++) begin
        do_issue(w, w * 16 + j, ok);
        chk(ok, "R8 accept within capacity", int'(ok), 1);
      end
    do_issue(0, 250, ok);
    chk(!ok, "R8 refuse when all reserved", int'(ok), 0);
    chk(ret_ready == 1'b1, "R9 empty buffer ready", int'(ret_ready), 1);
    for (int w = 0; w < 4; w++)
      for (int j = 0; j < 4; j++) do_ret(w);
    @(negedge clk);
    chk(ret_ready == 1'b0, "R9 full buffer", int'(ret_ready), 0);
    chk(wr_n == 0, "R3 full buffer no write", wr_n, 0);
    for (int w = 0; w < 4; w++) begin
      do_wait(w, 0);
      stall_len(w, n);
      chk(n == 6, "R6 drain of four", n, 6);
    end
    chk(ret_ready == 1'b1, "R9 ready after drain", int'(ret_ready), 1);
    verify_writes("R5 full drain", 16);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule